// File: doc/BRIEF.md
# Saturating Accumulator Condition-Code Unit

This block sits at the output of a 36-bit accumulator data path. Each result it receives has a 4-bit extension field, a 16-bit upper word and a 16-bit lower word. When saturation is enabled, the block clamps any result that does not fit in 32 signed bits. The clamped value leaves the block combinationally in the same cycle. The block also evaluates seven condition flags and registers them on a clock edge where the update strobe is high.

Two mode inputs shape the behaviour. The saturation-enable bit turns the output limiter on. The flag-width bit chooses how the flags read the result:

- **Width bit 0:** the flags read all 36 bits, and the extension is treated as valid.
- **Width bit 1:** the flags read only the low 32 bits, which is the view that unsigned compares need.

A small instruction-class code tells the block which operation produced the result. The code matters because the effect of saturation on the flags depends on the operation. A limiter event can force the overflow flag and the unnormalized flag. It can also set the sticky limit flag, which only an explicit clear input resets.

Top module: `sat_ccu`

## Requirements
- R1: The flag output is packed as [6]=L (sticky limit), [5]=E (extension in use), [4]=U (unnormalized), [3]=N, [2]=Z, [1]=V, [0]=C. A synchronous active-low reset sets all seven flags to 0. Bits [5:0] change only on a rising edge where `flag_upd` is 1.
- R2: With `sat_en`=1, a result whose bits [35:31] are not all equal leaves as 36'h0_7FFF_FFFF when bit 35 is 0 and as 36'hF_8000_0000 when bit 35 is 1. Any other result, and every result with `sat_en`=0, leaves unchanged.
- R3: When the limiter clamps a value and the class is neither test (code 1) nor compare (code 2), the next registered V is 1 and U is 0.
- R4: E is 1 when raw bits [35:31] are not all equal, in both width modes. Z is 1 when raw bits [31:0] are zero in 32-bit mode, and when all 36 raw bits are zero in 36-bit mode.
- R5: Before any forcing, U is 1 when raw bits 31 and 30 are equal in 32-bit mode, and when raw bits 32 and 31 are equal in 36-bit mode.
- R6: Before any forcing, V is raw bit 32 XOR raw bit 31 in 32-bit mode, and raw bit 35 XOR raw bit 34 in 36-bit mode.
- R7: L becomes 1 on any update whose V is 1 and then holds. `l_clr` clears L on the next edge. When `l_clr` arrives together with an update whose V is 1, L ends at 1.
- R8: Class codes are 0 generic, 1 test, 2 compare, 3 arithmetic shift into accumulator, 4 logical shift into accumulator, 5 integer multiply, 6 arithmetic shift left, and 7 generic. For test and compare, `sat_en` does not change any flag, except that a clamp during compare still forces U to 0.
- R9: N is the sign of the selected view: bit 31 in 32-bit mode and bit 35 in 36-bit mode. It is read from the limited result for classes 3, 4 and 5, and from the raw result for all other classes.
- R10: C equals `carry_in`, except for class 6 with a clamp, where C is bit 35 of the limited result.
- R11: In 32-bit mode the registered C and Z give the unsigned conditions HI = !C&!Z, HS = !C, LO = C and LS = C|Z.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_in | input | 36 | Raw data-path result |
| carry_in | input | 1 | Carry from the arithmetic stage |
| op_class | input | 3 | Instruction class code |
| sat_en | input | 1 | Output limiter enable |
| width32 | input | 1 | 1: flags read low 32 bits; 0: flags read all 36 bits |
| flag_upd | input | 1 | Load new flags on this edge |
| l_clr | input | 1 | Clear the sticky limit flag |
| res_out | output | 36 | Limited result, combinational |
| flags_out | output | 7 | Registered flags {L,E,U,N,Z,V,C} |

## Verification
Two functions can fall on the same edge: the sticky limit flag being cleared, and a new update that carries V=1, either from a clamp or from the base overflow rule. The bench drives `l_clr` together with `flag_upd` on saturating results, and also with `flag_upd` low. It judges L against a model in which the clear acts first and the new V is then ORed in. The bench also provokes clamps under every class code in both width modes. It compares all seven flags and the limited result against the model on every clock.

// File: rtl/sat_ccu_pkg.sv
// Package: shared class codes and the flag record for the condition-code unit.
// Assumes the class encoding is fixed by the instruction decoder upstream.
package sat_ccu_pkg;

    typedef enum logic [2:0] {
        CLS_GEN   = 3'd0,
        CLS_TST   = 3'd1,
        CLS_CMP   = 3'd2,
        CLS_SHRA  = 3'd3,
        CLS_SHRL  = 3'd4,
        CLS_IMUL  = 3'd5,
        CLS_SHL   = 3'd6,
        CLS_GEN2  = 3'd7
    } ccu_class_e;

    typedef struct packed {
        logic lim;   // sticky limit
        logic ext;   // extension in use
        logic unn;   // unnormalized
        logic neg;
        logic zer;
        logic ovf;
        logic cry;
    } ccu_flags_t;

endpackage

// File: rtl/sat_limiter.sv
// Module: sat_limiter
// Clamps a result to the signed 32-bit range when enabled.
// Assumes the value is EXT_W extension bits above two PORT_W-bit words.
module sat_limiter #(
    parameter int EXT_W  = 4,
    parameter int PORT_W = 16,
    localparam int LW    = 2 * PORT_W,
    localparam int W     = EXT_W + LW
) (
    input  logic [W-1:0] raw,
    input  logic         sat_en,
    output logic [W-1:0] lim,
    output logic         sat_hit
);
    logic [EXT_W:0] top_bits;
    logic           fits;

    // Detect whether the value is already representable in LW signed bits.
    always_comb begin
        top_bits = raw[W-1:LW-1];
        fits     = (&top_bits) | ~(|top_bits);
        sat_hit  = sat_en & ~fits;
    end

    // Select the clamped extreme or the untouched value.
    always_comb begin
        if (!sat_hit)
            lim = raw;
        else if (raw[W-1])
            lim = {{(EXT_W+1){1'b1}}, {(LW-1){1'b0}}};
        else
            lim = {{(EXT_W+1){1'b0}}, {(LW-1){1'b1}}};
    end
endmodule

// File: rtl/ccu_flag_logic.sv
// Module: ccu_flag_logic
// Computes the next condition flags (all but the sticky limit flag).
// Assumes raw and limited values are consistent with sat_hit.
module ccu_flag_logic
    import sat_ccu_pkg::*;
#(
    parameter int EXT_W  = 4,
    parameter int PORT_W = 16,
    localparam int LW    = 2 * PORT_W,
    localparam int W     = EXT_W + LW
) (
    input  logic [W-1:0] raw,
    input  logic [W-1:0] lim,
    input  logic         sat_hit,
    input  logic         carry_in,
    input  ccu_class_e   cls,
    input  logic         width32,
    output ccu_flags_t   nxt
);
    logic         test_like;
    logic         shift_like;
    logic [W-1:0] nsrc;
    logic         u_base;
    logic         v_base;

    // Classify the operation for the saturation exceptions.
    always_comb begin
        test_like  = (cls == CLS_TST) || (cls == CLS_CMP);
        shift_like = (cls == CLS_SHRA) || (cls == CLS_SHRL) || (cls == CLS_IMUL);
        nsrc       = shift_like ? lim : raw;
    end

    // Base U and V before saturation forcing, per width view.
    always_comb begin
        if (width32) begin
            u_base = ~(raw[LW-1] ^ raw[LW-2]);
            v_base = raw[LW] ^ raw[LW-1];
        end else begin
            u_base = ~(raw[LW] ^ raw[LW-1]);
            v_base = raw[W-1] ^ raw[W-2];
        end
    end

    // Assemble the next flag record.
    always_comb begin
        nxt     = '0;
        nxt.ext = ~((&raw[W-1:LW-1]) | ~(|raw[W-1:LW-1]));
        nxt.zer = width32 ? ~(|raw[LW-1:0]) : ~(|raw);
        nxt.neg = width32 ? nsrc[LW-1] : nsrc[W-1];
        nxt.unn = u_base & ~(sat_hit & (cls != CLS_TST));
        nxt.ovf = v_base | (sat_hit & ~test_like);
        nxt.cry = ((cls == CLS_SHL) && sat_hit) ? lim[W-1] : carry_in;
    end
endmodule

// File: rtl/ccu_flag_reg.sv
// Module: ccu_flag_reg
// Holds the flags; L is a sticky OR of V, cleared only by l_clr.
// Assumes a synchronous active-low reset.
module ccu_flag_reg
    import sat_ccu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       upd,
    input  logic       l_clr,
    input  ccu_flags_t nxt,
    output ccu_flags_t q
);
    // Load the flags on update; fold new V into the sticky bit after any clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            if (upd) begin
                q.ext <= nxt.ext;
                q.unn <= nxt.unn;
                q.neg <= nxt.neg;
                q.zer <= nxt.zer;
                q.ovf <= nxt.ovf;
                q.cry <= nxt.cry;
            end
            q.lim <= (l_clr ? 1'b0 : q.lim) | (upd & nxt.ovf);
        end
    end

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(q[5:0])); // R1
    AST_L_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (q.lim && !l_clr) |=> q.lim); // R7
    AST_L_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (l_clr && !upd) |=> !q.lim); // R7
endmodule

// File: rtl/sat_ccu.sv
// Module: sat_ccu
// Top of the saturating condition-code unit: limiter, flag logic, flag register.
// Assumes op_class is valid in the cycle that flag_upd is high.
module sat_ccu
    import sat_ccu_pkg::*;
#(
    parameter int EXT_W  = 4,
    parameter int PORT_W = 16,
    localparam int LW    = 2 * PORT_W,
    localparam int W     = EXT_W + LW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] res_in,
    input  logic         carry_in,
    input  logic [2:0]   op_class,
    input  logic         sat_en,
    input  logic         width32,
    input  logic         flag_upd,
    input  logic         l_clr,
    output logic [W-1:0] res_out,
    output logic [6:0]   flags_out
);
    logic       sat_hit;
    ccu_class_e cls;
    ccu_flags_t nxt;
    ccu_flags_t q;

    // Decode the class code into the shared enum.
    always_comb cls = ccu_class_e'(op_class);

    sat_limiter #(.EXT_W(EXT_W), .PORT_W(PORT_W)) u_lim (
        .raw     (res_in),
        .sat_en  (sat_en),
        .lim     (res_out),
        .sat_hit (sat_hit)
    );

    ccu_flag_logic #(.EXT_W(EXT_W), .PORT_W(PORT_W)) u_logic (
        .raw      (res_in),
        .lim      (res_out),
        .sat_hit  (sat_hit),
        .carry_in (carry_in),
        .cls      (cls),
        .width32  (width32),
        .nxt      (nxt)
    );

    ccu_flag_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (flag_upd),
        .l_clr (l_clr),
        .nxt   (nxt),
        .q     (q)
    );

    // Present the flag record on the output pins.
    always_comb flags_out = q;

    AST_LIMIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        sat_en |-> ((&res_out[W-1:LW-1]) || !(|res_out[W-1:LW-1]))); // R2
    AST_SAT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_upd && sat_en && (res_out != res_in) && op_class != 3'd1 && op_class != 3'd2)
        |=> (flags_out[1] && !flags_out[4])); // R3
    AST_SAT_SETS_L: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_upd && sat_en && (res_out != res_in) && op_class > 3'd2) |=> flags_out[6]); // R7
endmodule

// File: tb/sat_ccu_test.sv
`timescale 1ns/1ps
module sat_ccu_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [35:0] res_in;
    logic        carry_in;
    logic [2:0]  op_class;
    logic        sat_en, width32, flag_upd, l_clr;
    logic [35:0] res_out;
    logic [6:0]  flags_out;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;
    logic [6:0] exp_fl;

    always #2.5 clk = ~clk;

    sat_ccu uut (
        .clk(clk), .rst_n(rst_n), .res_in(res_in), .carry_in(carry_in),
        .op_class(op_class), .sat_en(sat_en), .width32(width32),
        .flag_upd(flag_upd), .l_clr(l_clr), .res_out(res_out), .flags_out(flags_out)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
        nchk++;
        if (act !== expv) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic bit m_fits(input logic [35:0] r);
        longint s;
        s = longint'($signed(r));
        return (s >= -64'sd2147483648) && (s <= 64'sd2147483647);
    endfunction

    function automatic logic [35:0] m_lim(input logic [35:0] r, input bit se);
        if (!se || m_fits(r)) return r;
        return r[35] ? 36'hF_8000_0000 : 36'h0_7FFF_FFFF;
    endfunction

    // returns {E,U,N,Z,V,C}
    function automatic logic [5:0] m_flags(input logic [35:0] r, input bit cy,
                                           input int cls, input bit se, input bit w);
        bit sat, e, u, n, z, v, c;
        logic [35:0] l;
        sat = se && !m_fits(r);
        l   = m_lim(r, se);
        e   = !m_fits(r);
        z   = w ? (r[31:0] == 0) : (r == 0);
        u   = w ? (r[31] == r[30]) : (r[32] == r[31]);
        if (sat && cls != 1) u = 0;
        v   = w ? (r[32] != r[31]) : (r[35] != r[34]);
        if (sat && cls != 1 && cls != 2) v = 1;
        if (cls == 3 || cls == 4 || cls == 5) n = w ? l[31] : l[35];
        else n = w ? r[31] : r[35];
        c = (cls == 6 && sat) ? l[35] : cy;
        return {e, u, n, z, v, c};
    endfunction

    // Compare registered flags against the model, tagged by requirement.
    task automatic cmp_flags();
        chk("R7 L",  flags_out[6], exp_fl[6]);
        chk("R4 E",  flags_out[5], exp_fl[5]);
        chk("R5 U",  flags_out[4], exp_fl[4]);
        chk("R9 N",  flags_out[3], exp_fl[3]);
        chk("R4 Z",  flags_out[2], exp_fl[2]);
        chk("R6/R3 V", flags_out[1], exp_fl[1]);
        chk("R10 C", flags_out[0], exp_fl[0]);
    endtask

    // One cycle: check previous flags, drive, check limited output, predict.
    task automatic step(input logic [35:0] r, input bit cy, input int cls,
                        input bit se, input bit w, input bit u, input bit clr);
        logic [5:0] f;
        @(negedge clk);
        cmp_flags();
        res_in = r; carry_in = cy; op_class = 3'(cls); sat_en = se;
        width32 = w; flag_upd = u; l_clr = clr;
        #1;
        chk("R2 res_out", res_out, m_lim(r, se));
        f = m_flags(r, cy, cls, se, w);
        if (u) exp_fl[5:0] = f;
        exp_fl[6] = (clr ? 1'b0 : exp_fl[6]) | (u & f[1]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [6:0] f_a;
        rst_n = 0; res_in = 36'h0_1234_5678; carry_in = 1; op_class = 0;
        sat_en = 0; width32 = 0; flag_upd = 1; l_clr = 0;
        exp_fl = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset", flags_out, 7'b0);
        rst_n = 1; flag_upd = 0;

        // R1: no update, flags hold
        step(36'h8_0000_0000, 1, 0, 1, 0, 0, 0);
        step(36'h0_0000_0001, 0, 0, 0, 0, 0, 0);
        // R2 clamps and pass-through
        step(36'h1_0000_0000, 0, 0, 1, 0, 1, 0);
        chk("R2 pos clamp", res_out, 36'h0_7FFF_FFFF);
        step(36'hE_0000_0000, 0, 0, 1, 0, 1, 0);
        chk("R2 neg clamp", res_out, 36'hF_8000_0000);
        step(36'hE_0000_0000, 0, 0, 0, 0, 1, 1);
        chk("R2 passthrough", res_out, 36'hE_0000_0000);
        // R7: clear without update, then clear with saturating update
        step(36'h0_0000_0000, 0, 0, 0, 1, 0, 1);
        step(36'h3_0000_0000, 1, 5, 1, 1, 1, 1);
        step(36'h0_0000_0000, 0, 0, 0, 0, 0, 1);
        // R9/R10 saturation exception classes in both widths
        for (int k = 0; k < 8; k++) begin
            step(36'h2_4000_0000, 1, k, 1, 1, 1, 0);
            step(36'hD_0000_0001, 0, k, 1, 0, 1, 0);
        end
        // R8: test class flags identical with and without saturation
        step(36'h5_0000_0000, 1, 1, 1, 0, 1, 1);
        @(negedge clk); f_a = flags_out;
        step(36'h5_0000_0000, 1, 1, 0, 0, 1, 1);
        @(negedge clk);
        chk("R8 tst sat-independent", flags_out[5:0], f_a[5:0]);
        step(36'h5_0000_0000, 1, 2, 1, 1, 1, 1);
        step(36'h5_0000_0000, 1, 2, 0, 1, 1, 1);
        // R5/R6/R4 boundary patterns
        step(36'h0_0000_0000, 0, 0, 0, 1, 1, 1);
        step(36'hF_0000_0000, 0, 0, 0, 1, 1, 0);
        step(36'h0_C000_0000, 0, 0, 0, 0, 1, 1);
        step(36'h0_8000_0000, 0, 0, 0, 1, 1, 1);
        // random traffic, with R11 unsigned-condition checks in 32-bit mode
        for (int i = 0; i < 3000; i++) begin
            logic [35:0] r;
            bit w;
            r = {$urandom_range(15, 0), $urandom};
            if (i % 5 == 0) r = {{5{r[35]}}, r[30:0]};
            w = $urandom_range(1, 0);
            step(r, $urandom_range(1, 0), $urandom_range(7, 0), $urandom_range(1, 0),
                 w, ($urandom_range(3, 0) != 0), ($urandom_range(7, 0) == 0));
            if (width32) begin
                @(negedge clk);
                chk("R11 HI", !flags_out[0] && !flags_out[2], !exp_fl[0] && !exp_fl[2]);
                chk("R11 HS", !flags_out[0], !exp_fl[0]);
                chk("R11 LO", flags_out[0], exp_fl[0]);
                chk("R11 LS", flags_out[0] || flags_out[2], exp_fl[0] || exp_fl[2]);
            end
        end
        @(negedge clk);
        cmp_flags();
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule